// File: doc/BRIEF.md
# UART Transmit Buffer and Status Flags

This block is the sending half of a serial port. A processor hands it bytes one at a time through a write strobe. The block turns each byte into an asynchronous frame on a single output line. The frame has one low start bit, eight data bits with the least significant bit first, and one high stop bit. Every bit lasts sixteen baud ticks. A plain clock divider produces those ticks. Between the write port and the shift register sits either a single holding slot or a small queue. A mode input selects which one.

The block also produces the status flags that software needs to pace its writes:

- **Empty flag.** Set while the holding slot or queue has nothing waiting.
- **Room flag.** In queue mode, says the queue can take another byte.
- **Threshold flag.** Set when the queue has drained to a selectable fill level.
- **Sticky completion flag.** Set once the line has gone quiet with nothing left to send.
- **Sticky overflow flag.** Records writes that were dropped.

One interrupt line carries the logical OR of the room, threshold and completion flags. Each of these three passes only if its own enable input is set.

Top module: `uarttx_flag_ctrl`

## Requirements
- R1: A write that arrives while no frame is being sent and nothing is waiting loads the byte straight into the shifter. The start bit appears on `txd` in the next cycle, and `txe` stays 1 throughout. The same direct load happens when the write falls in the final cycle of a frame and nothing is waiting.
- R2: Frame shape:
  - `txd` idles at 1.
  - A frame is bit 0 = start (0), bits 1..8 = data LSB first, bit 9 = stop (1).
  - Each bit lasts 16 × BAUD_DIV clock cycles.
  - Back-to-back frames follow with no idle gap.
- R3: With `fifo_mode` = 0 there is one holding slot. A write accepted during a frame drops `txe` to 0 in the next cycle. The waiting byte is loaded into the shifter at the end of the current frame, and `txe` returns to 1 at that moment.
- R4: With `fifo_mode` = 1, `fifo_nf` is 1 whenever the queue holds fewer than FIFO_DEPTH (8) bytes. It stays 1 across writes and goes to 0 only when the queue is full. With `fifo_mode` = 0, `fifo_nf` is 0.
- R5: In queue mode, bytes leave in the order they were written. The oldest one is loaded at the end of each frame.
- R6: `thr_hit` is 1 only in queue mode, and only when the fill count is at or below the level selected by `thr_sel`:
  - code 0 = 1/8 of depth
  - code 1 = 1/4
  - code 2 = 1/2
  - code 3 = 3/4
  - code 4 = 7/8
  - codes 5 to 7 = empty (0 entries)
- R7: `tx_done` rises after the stop bit of a frame only if no byte is waiting at that moment. It is 0 while a frame is being sent.
- R8: `tx_done` stays 1 until a write or a `done_clr` pulse clears it. A clear takes priority over a same-cycle set. `tx_done` is 0 after reset.
- R9: A write that finds the storage full is dropped: 1 entry in single mode, FIFO_DEPTH entries in queue mode. Fullness is judged before any pop in the same cycle. A dropped write sets `ovf_err`, which only reset clears. The dropped byte never appears on `txd`.
- R10: The room source is `fifo_nf` in queue mode and `txe` in single mode. `irq` = (`ie_room` & room source) | (`ie_thr` & `thr_hit`) | (`ie_done` & `tx_done`).
- R11: After synchronous reset:
  - `txd` = 1
  - `txe` = 1
  - `tx_done` = 0
  - `ovf_err` = 0
  - the storage is empty

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for one byte |
| wr_data | input | 8 | Byte to send |
| fifo_mode | input | 1 | 0 = single holding slot, 1 = queue of FIFO_DEPTH entries |
| thr_sel | input | 3 | Threshold level code |
| ie_room | input | 1 | Interrupt enable for the room source |
| ie_thr | input | 1 | Interrupt enable for `thr_hit` |
| ie_done | input | 1 | Interrupt enable for `tx_done` |
| done_clr | input | 1 | Clears `tx_done` |
| txd | output | 1 | Serial output line |
| txe | output | 1 | Storage empty |
| fifo_nf | output | 1 | Queue not full (queue mode only) |
| thr_hit | output | 1 | Fill count at or below the selected threshold |
| tx_done | output | 1 | Sticky transmission complete |
| ovf_err | output | 1 | Sticky dropped-write error |
| irq | output | 1 | Masked interrupt |

## Verification
Two functions can land in the same cycle: the end of a frame, and a processor write. When nothing is waiting, such a write must bypass into the shifter and start the next frame with no gap. When storage is full, the write must be dropped even though a byte leaves in that same cycle. The bench tracks its own frame position and places writes in exactly the final cycle of a frame, in both single and queue mode. A behavioural queue model then judges `txd`, every flag and `irq` on each clock.

// File: rtl/uarttx_pkg.sv
package uarttx_pkg;

    localparam int unsigned TICKS_PER_BIT  = 16;
    localparam int unsigned BITS_PER_FRAME = 10;
    localparam int unsigned TICK_W         = $clog2(TICKS_PER_BIT);
    localparam int unsigned BIT_W          = $clog2(BITS_PER_FRAME);

    typedef enum logic [2:0] {
        THR_EIGHTH   = 3'd0,
        THR_QUARTER  = 3'd1,
        THR_HALF     = 3'd2,
        THR_3QUARTER = 3'd3,
        THR_7EIGHTH  = 3'd4,
        THR_EMPTY    = 3'd5
    } thr_code_e;

    typedef struct packed {
        logic               busy;
        logic [BIT_W-1:0]   bit_idx;
        logic [TICK_W-1:0]  tick_cnt;
        logic [7:0]         data;
    } shift_state_t;

    typedef struct packed {
        logic txe;
        logic fifo_nf;
        logic thr_hit;
        logic tx_done;
        logic ovf_err;
    } tx_flags_t;

    function automatic int unsigned thr_level(input logic [2:0] code, input int unsigned depth);
        case (code)
            THR_EIGHTH:   return depth / 8;
            THR_QUARTER:  return depth / 4;
            THR_HALF:     return depth / 2;
            THR_3QUARTER: return (3 * depth) / 4;
            THR_7EIGHTH:  return (7 * depth) / 8;
            default:      return 0;
        endcase
    endfunction

endpackage

// File: rtl/uarttx_baud.sv
module uarttx_baud #(
    parameter int unsigned BAUD_DIV = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic restart,
    output logic tick
);
    localparam int unsigned CW = (BAUD_DIV > 1) ? $clog2(BAUD_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(BAUD_DIV - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || restart || !run) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = run && (cnt == LAST);

endmodule

// File: rtl/uarttx_store.sv
module uarttx_store #(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned W     = 8
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         push,
    input  logic                         pop,
    input  logic [W-1:0]                 din,
    output logic [W-1:0]                 head,
    output logic [$clog2(DEPTH+1)-1:0]   count
);
    localparam int unsigned PW = $clog2(DEPTH);
    localparam int unsigned CW = $clog2(DEPTH+1);
    localparam logic [PW-1:0] PLAST = PW'(DEPTH - 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wp, rp;

    genvar gi;
    generate
        for (gi = 0; gi < DEPTH; gi++) begin : g_slot
            always_ff @(posedge clk) begin
                if (push && (wp == PW'(gi))) begin
                    mem[gi] <= din;
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (push) begin
                wp <= (wp == PLAST) ? '0 : wp + 1'b1;
            end
            if (pop) begin
                rp <= (rp == PLAST) ? '0 : rp + 1'b1;
            end
            count <= count + CW'(push) - CW'(pop);
        end
    end

    assign head = mem[rp];

endmodule

// File: rtl/uarttx_shift.sv
module uarttx_shift
    import uarttx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  logic [7:0] load_data,
    input  logic       tick,
    output logic       busy,
    output logic       frame_end,
    output logic       txd
);
    localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(TICKS_PER_BIT - 1);
    localparam logic [BIT_W-1:0]  BIT_STOP  = BIT_W'(BITS_PER_FRAME - 1);

    shift_state_t st;

    assign busy      = st.busy;
    assign frame_end = st.busy && tick && (st.tick_cnt == TICK_LAST) && (st.bit_idx == BIT_STOP);

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else if (load) begin
            st.busy     <= 1'b1;
            st.bit_idx  <= '0;
            st.tick_cnt <= '0;
            st.data     <= load_data;
        end else if (frame_end) begin
            st.busy <= 1'b0;
        end else if (st.busy && tick) begin
            st.tick_cnt <= st.tick_cnt + 1'b1;
            if (st.tick_cnt == TICK_LAST) begin
                st.bit_idx <= st.bit_idx + 1'b1;
            end
        end
    end

    always_comb begin
        if (!st.busy) begin
            txd = 1'b1;
        end else if (st.bit_idx == '0) begin
            txd = 1'b0;
        end else if (st.bit_idx == BIT_STOP) begin
            txd = 1'b1;
        end else begin
            txd = st.data[3'(st.bit_idx[2:0] - 3'd1)];
        end
    end

endmodule

// File: rtl/uarttx_flag_ctrl.sv
module uarttx_flag_ctrl
    import uarttx_pkg::*;
#(
    parameter int unsigned FIFO_DEPTH = 8,
    parameter int unsigned BAUD_DIV   = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       fifo_mode,
    input  logic [2:0] thr_sel,
    input  logic       ie_room,
    input  logic       ie_thr,
    input  logic       ie_done,
    input  logic       done_clr,
    output logic       txd,
    output logic       txe,
    output logic       fifo_nf,
    output logic       thr_hit,
    output logic       tx_done,
    output logic       ovf_err,
    output logic       irq
);
    localparam int unsigned CW = $clog2(FIFO_DEPTH + 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(FIFO_DEPTH);

    logic [CW-1:0] fill_cnt;
    logic [7:0]    head_byte;
    logic          sh_busy, sh_end, baud_tick;
    logic          cap_full, bypass, do_push, do_pop, reject, load;
    logic [7:0]    load_byte;
    tx_flags_t     flags;
    logic          done_q, ovf_q;

    // Storage capacity depends on mode; fullness is judged before any pop.
    assign cap_full  = fifo_mode ? (fill_cnt == FULL_CNT) : (fill_cnt != '0);
    assign bypass    = wr_en && (fill_cnt == '0) && (!sh_busy || sh_end);
    assign do_push   = wr_en && !bypass && !cap_full;
    assign reject    = wr_en && !bypass && cap_full;
    assign do_pop    = sh_end && (fill_cnt != '0);
    assign load      = bypass || do_pop;
    assign load_byte = bypass ? wr_data : head_byte;

    uarttx_store #(.DEPTH(FIFO_DEPTH), .W(8)) store_i (
        .clk   (clk),
        .rst   (rst),
        .push  (do_push),
        .pop   (do_pop),
        .din   (wr_data),
        .head  (head_byte),
        .count (fill_cnt)
    );

    uarttx_baud #(.BAUD_DIV(BAUD_DIV)) baud_i (
        .clk     (clk),
        .rst     (rst),
        .run     (sh_busy),
        .restart (load),
        .tick    (baud_tick)
    );

    uarttx_shift shift_i (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .load_data (load_byte),
        .tick      (baud_tick),
        .busy      (sh_busy),
        .frame_end (sh_end),
        .txd       (txd)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            done_q <= 1'b0;
            ovf_q  <= 1'b0;
        end else begin
            if (wr_en || done_clr) begin
                done_q <= 1'b0;
            end else if (sh_end && (fill_cnt == '0)) begin
                done_q <= 1'b1;
            end
            if (reject) begin
                ovf_q <= 1'b1;
            end
        end
    end

    always_comb begin
        flags.txe     = (fill_cnt == '0);
        flags.fifo_nf = fifo_mode && (fill_cnt != FULL_CNT);
        flags.thr_hit = fifo_mode && (32'(fill_cnt) <= thr_level(thr_sel, FIFO_DEPTH));
        flags.tx_done = done_q;
        flags.ovf_err = ovf_q;
    end

    assign txe     = flags.txe;
    assign fifo_nf = flags.fifo_nf;
    assign thr_hit = flags.thr_hit;
    assign tx_done = flags.tx_done;
    assign ovf_err = flags.ovf_err;
    assign irq     = (ie_room && (fifo_mode ? flags.fifo_nf : flags.txe))
                   || (ie_thr && flags.thr_hit)
                   || (ie_done && flags.tx_done);

endmodule

// File: rtl/uarttx_flag_ctrl_chk.sv
module uarttx_flag_ctrl_chk #(
    parameter int unsigned FIFO_DEPTH = 8
) (
    input logic                           clk,
    input logic                           rst,
    input logic                           wr_en,
    input logic                           done_clr,
    input logic                           fifo_mode,
    input logic                           ie_room,
    input logic                           ie_thr,
    input logic                           ie_done,
    input logic                           txd,
    input logic                           txe,
    input logic                           fifo_nf,
    input logic                           thr_hit,
    input logic                           tx_done,
    input logic                           ovf_err,
    input logic                           irq,
    input logic                           busy,
    input logic                           frame_end,
    input logic [$clog2(FIFO_DEPTH+1)-1:0] fill_cnt
);
    localparam int unsigned CW = $clog2(FIFO_DEPTH + 1);

    assert_idle_write_starts_R1: assert property (@(posedge clk) disable iff (rst)
        (wr_en && txe && !busy) |=> (busy && !txd && txe));

    assert_stop_bit_high_R2: assert property (@(posedge clk) disable iff (rst)
        frame_end |-> txd);

    assert_start_bit_low_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> !txd);

    assert_hold_clears_txe_R3: assert property (@(posedge clk) disable iff (rst)
        (!fifo_mode && busy && !frame_end && wr_en && txe) |=> !txe);

    assert_nf_stays_R4: assert property (@(posedge clk) disable iff (rst)
        (fifo_mode && busy && !frame_end && wr_en && (fill_cnt < CW'(FIFO_DEPTH - 1)))
        |=> (!fifo_mode || fifo_nf));

    assert_thr_needs_mode_R6: assert property (@(posedge clk) disable iff (rst)
        !fifo_mode |-> !thr_hit);

    assert_done_when_drained_R7: assert property (@(posedge clk) disable iff (rst)
        (frame_end && (fill_cnt == '0) && !wr_en && !done_clr) |=> tx_done);

    assert_done_not_busy_R7: assert property (@(posedge clk) disable iff (rst)
        tx_done |-> !busy);

    assert_done_cleared_R8: assert property (@(posedge clk) disable iff (rst)
        (wr_en || done_clr) |=> !tx_done);

    assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        ovf_err |=> ovf_err);

    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && fifo_mode && (fill_cnt == CW'(FIFO_DEPTH))) |=> ovf_err);

    assert_irq_masked_R10: assert property (@(posedge clk) disable iff (rst)
        (!ie_room && !ie_thr && !ie_done) |-> !irq);

endmodule

bind uarttx_flag_ctrl uarttx_flag_ctrl_chk #(.FIFO_DEPTH(FIFO_DEPTH)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .done_clr  (done_clr),
    .fifo_mode (fifo_mode),
    .ie_room   (ie_room),
    .ie_thr    (ie_thr),
    .ie_done   (ie_done),
    .txd       (txd),
    .txe       (txe),
    .fifo_nf   (fifo_nf),
    .thr_hit   (thr_hit),
    .tx_done   (tx_done),
    .ovf_err   (ovf_err),
    .irq       (irq),
    .busy      (sh_busy),
    .frame_end (sh_end),
    .fill_cnt  (fill_cnt)
);

// File: tb/uarttx_flag_ctrl_tb_top.sv
module uarttx_flag_ctrl_tb_top;
    localparam int DEPTH = 8;
    localparam int DIV   = 2;
    localparam int BITC  = 16 * DIV;
    localparam int FRAME = 10 * BITC;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       fifo_mode = 1'b0;
    logic [2:0] thr_sel = 3'd0;
    logic       ie_room = 1'b0, ie_thr = 1'b0, ie_done = 1'b0;
    logic       done_clr = 1'b0;
    logic       txd, txe, fifo_nf, thr_hit, tx_done, ovf_err, irq;

    int checks = 0;
    int failures = 0;
    bit chk_on = 1'b0;
    bit finished = 1'b0;

    // reference model state
    int         m_busy = 0;
    int         m_cyc = 0;
    logic [7:0] m_byte = 8'h00;
    logic [7:0] m_q[$];
    logic       m_done = 1'b0;
    logic       m_ovf = 1'b0;

    always #5 clk = ~clk;

    uarttx_flag_ctrl #(.FIFO_DEPTH(DEPTH), .BAUD_DIV(DIV)) dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .fifo_mode(fifo_mode), .thr_sel(thr_sel),
        .ie_room(ie_room), .ie_thr(ie_thr), .ie_done(ie_done),
        .done_clr(done_clr), .txd(txd), .txe(txe), .fifo_nf(fifo_nf),
        .thr_hit(thr_hit), .tx_done(tx_done), .ovf_err(ovf_err), .irq(irq)
    );

    function automatic int lvl(input logic [2:0] c);
        case (c)
            3'd0: return 1;
            3'd1: return 2;
            3'd2: return 4;
            3'd3: return 6;
            3'd4: return 7;
            default: return 0;
        endcase
    endfunction

    function automatic logic m_txd();
        int b;
        if (m_busy == 0) return 1'b1;
        b = m_cyc / BITC;
        if (b == 0) return 1'b0;
        if (b == 9) return 1'b1;
        return m_byte[b-1];
    endfunction

    function automatic logic m_txe();  return m_q.size() == 0; endfunction
    function automatic logic m_nf();   return fifo_mode && (m_q.size() < DEPTH); endfunction
    function automatic logic m_thr();  return fifo_mode && (m_q.size() <= lvl(thr_sel)); endfunction
    function automatic logic m_irq();
        logic room;
        room = fifo_mode ? m_nf() : m_txe();
        return (ie_room && room) || (ie_thr && m_thr()) || (ie_done && m_done);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_busy = 0; m_cyc = 0; m_q.delete(); m_done = 1'b0; m_ovf = 1'b0;
        end else begin
            int  n;
            bit  fe, byp, psh, rej;
            int  cap;
            n   = m_q.size();
            fe  = (m_busy != 0) && (m_cyc == FRAME - 1);
            cap = fifo_mode ? DEPTH : 1;
            byp = wr_en && (n == 0) && ((m_busy == 0) || fe);
            psh = wr_en && !byp && (n < cap);
            rej = wr_en && !byp && (n >= cap);
            if (wr_en || done_clr) m_done = 1'b0;
            else if (fe && n == 0) m_done = 1'b1;
            if (rej) m_ovf = 1'b1;
            if (byp) begin
                m_busy = 1; m_cyc = 0; m_byte = wr_data;
            end else if (fe && n > 0) begin
                m_byte = m_q.pop_front(); m_cyc = 0;
            end else if (fe) begin
                m_busy = 0;
            end else if (m_busy != 0) begin
                m_cyc++;
            end
            if (psh) m_q.push_back(wr_data);
        end
    end

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s t=%0t actual=%b expected=%b", tag, $time, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (chk_on && !finished) begin
            check("R2 R5 txd", txd, m_txd());
            check("R1 R3 txe", txe, m_txe());
            check("R4 fifo_nf", fifo_nf, m_nf());
            check("R6 thr_hit", thr_hit, m_thr());
            check("R7 R8 tx_done", tx_done, m_done);
            check("R9 ovf_err", ovf_err, m_ovf);
            check("R10 irq", irq, m_irq());
        end
    end

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic put(input logic [7:0] d);
        wr_en = 1'b1; wr_data = d;
        step();
        wr_en = 1'b0;
    endtask

    task automatic wait_fe();
        while (!(m_busy != 0 && m_cyc == FRAME - 1)) step();
    endtask

    task automatic wait_idle();
        while (m_busy != 0 || m_q.size() != 0) step();
        step();
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) step();
        rst = 1'b0;
        step();
        // R11 reset state
        check("R11 txd", txd, 1'b1);
        check("R11 txe", txe, 1'b1);
        check("R11 tx_done", tx_done, 1'b0);
        check("R11 ovf_err", ovf_err, 1'b0);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        #2;
        do_reset();
        chk_on = 1'b1;

        // single-slot mode
        ie_room = 1'b1; ie_thr = 1'b1; ie_done = 1'b1;
        put(8'hA5);                  // R1 idle bypass
        repeat (20) step();
        put(8'h3C);                  // R3 held in slot
        put(8'h77);                  // R9 dropped, slot full
        wait_idle();
        repeat (10) step();
        done_clr = 1'b1; step(); done_clr = 1'b0;   // R8
        repeat (5) step();
        put(8'h0F);
        wait_fe();
        put(8'hF0);                  // R1 write in final frame cycle
        wait_fe();
        done_clr = 1'b1; step(); done_clr = 1'b0;   // R8 clear beats set
        put(8'h81);
        repeat (40) step();
        put(8'h18);
        wait_fe();
        put(8'hEE);                  // R9 slot full at frame end: dropped
        wait_idle();

        // queue mode, fresh reset
        do_reset();
        fifo_mode = 1'b1; ie_room = 1'b0; ie_thr = 1'b1; ie_done = 1'b0;
        thr_sel = 3'd0;
        step();
        for (int i = 0; i < 10; i++) put(8'(8'h11 * i + 8'h03));   // R4 R9
        for (int c = 0; c < 8; c++) begin
            thr_sel = 3'(c);         // R6 every code
            wait_fe();
            step();
            if (c == 1) put(8'h6B);
        end
        ie_room = 1'b1; ie_done = 1'b1; ie_thr = 1'b0;
        wait_idle();
        for (int i = 0; i < 9; i++) put(8'(8'h29 + 8'd7 * i));
        wait_fe();
        put(8'hD2);                  // R9 full at frame end: dropped
        thr_sel = 3'd2;
        wait_fe();
        put(8'h4D);                  // R5 refill while draining
        ie_room = 1'b0; ie_thr = 1'b0; ie_done = 1'b1;
        wait_idle();
        repeat (10) step();
        finish_run();
    end

endmodule